// File: doc/BRIEF.md
# Branch Target Buffer

This block gives the fetch stage a predicted next PC in the same cycle as the instruction memory access. The fetch PC is compared in parallel against every stored branch address. On a match the stored target is offered as the next fetch address. Without a match, fetch continues at PC+4. Each entry holds a valid bit, a word-aligned branch address tag and a word-aligned target.

A resolve port, driven by the execute stage, returns each branch with its real direction and target. It also returns whether fetch found it in the buffer and which next PC fetch used. The block sorts the outcome into one of three classes: correct, wrong prediction on a buffered branch, or a taken branch that was not buffered. For the last two it pulses kill and redirect for one cycle, with the corrected PC, so the front end can squash the instruction it fetched wrongly.

The same resolve updates the storage. Taken branches are written in, either into their existing entry or into a slot chosen by a round-robin pointer. A buffered branch that turns out not taken is dropped, so later fetches fall through.

Top module: `btb_top`

## Requirements
- R1: After reset no entry is valid: every fetch PC misses, and kill_o and redirect_o are low.
- R2: On a miss, pred_hit_o is 0 and pred_npc_o equals fetch_pc_i + 4.
- R3: A resolve with res_hit_i=0 and res_taken_i=1 sets kill_o and redirect_o in the next cycle, with redirect_pc_o = res_target_i and outcome_o = 2'b10. From then on a fetch of that PC hits and predicts res_target_i.
- R4: A resolve with res_hit_i=1, res_taken_i=1 and res_target_i equal to res_pred_npc_i gives outcome_o = 2'b00 and no kill or redirect.
- R5: A resolve with res_hit_i=1 and res_taken_i=0 gives kill and redirect with redirect_pc_o = res_pc_i + 4 and outcome_o = 2'b01. The entry is invalidated, so later fetches of that PC miss.
- R6: A resolve with res_hit_i=1, res_taken_i=1 and res_target_i different from res_pred_npc_i gives kill and redirect to res_target_i with outcome_o = 2'b01. The stored target is replaced by the new one.
- R7: A resolve with res_hit_i=0 and res_taken_i=0 gives outcome_o = 2'b00 and no kill, and nothing is inserted.
- R8: kill_o and redirect_o are single-cycle pulses. Each follows a resolve by exactly one cycle, and they are never high in a cycle that does not follow a resolve.
- R9: New entries fill slots in round-robin order starting at slot 0 after reset. The 17th distinct insertion evicts the first branch inserted.
- R10: A taken resolve for a branch address already in the buffer rewrites that entry. It neither creates a second copy nor advances the round-robin pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_pc_i | input | 32 | Current fetch address |
| pred_hit_o | output | 1 | Fetch address found in buffer |
| pred_npc_o | output | 32 | Predicted next fetch address |
| res_valid_i | input | 1 | Resolve port carries a branch this cycle |
| res_pc_i | input | 32 | Address of the resolved branch |
| res_taken_i | input | 1 | Actual direction |
| res_target_i | input | 32 | Actual taken target |
| res_hit_i | input | 1 | Branch hit in the buffer at fetch |
| res_pred_npc_i | input | 32 | Next PC that fetch used after the branch |
| kill_o | output | 1 | Squash the instruction fetched after the branch |
| redirect_o | output | 1 | Restart fetch at redirect_pc_o |
| redirect_pc_o | output | 32 | Corrected fetch address |
| outcome_o | output | 2 | 00 correct, 01 wrong buffered prediction, 10 taken miss |

## Verification
The assertions assume word-aligned PCs and targets. They also assume that res_hit_i and res_pred_npc_i are the values fetch actually saw, so that a hit always comes with the stored target. The stimulus drives only addresses with the low two bits clear, and it always pairs a hit flag with the target the buffer last held for that branch. Resolves are issued one at a time with an idle cycle between them. The round-robin and duplicate cases are reached by filling all sixteen slots from reset before any replacement.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    OUT_OK         = 2'b00,
    OUT_BAD_HIT    = 2'b01,
    OUT_TAKEN_MISS = 2'b10
  } outcome_e;
endpackage

// File: rtl/btb_cam.sv
module btb_cam #(
  parameter int N  = 16,
  parameter int TW = 30,
  localparam int IW = $clog2(N)
) (
  input  logic          valid_i [N],
  input  logic [TW-1:0] tag_i   [N],
  input  logic [TW-1:0] key_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tag_i[g] == key_i);
  end

  assign hit_o = |match_o;

  // entries are kept unique, so an OR of matching indices is exact
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (match_o[i]) idx_o = idx_o | IW'(i);
  end
endmodule

// File: rtl/btb_store.sv
module btb_store #(
  parameter int N  = 16,
  parameter int TW = 30,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [TW-1:0] wr_tag_i,
  input  logic [TW-1:0] wr_tgt_i,
  input  logic          inv_en_i,
  input  logic [IW-1:0] inv_idx_i,
  output logic          valid_o [N],
  output logic [TW-1:0] tag_o   [N],
  output logic [TW-1:0] tgt_o   [N]
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
      end else if (wr_en_i && wr_idx_i == IW'(g)) begin
        valid_o[g] <= 1'b1;
      end else if (inv_en_i && inv_idx_i == IW'(g)) begin
        valid_o[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_o[g] <= '0;
        tgt_o[g] <= '0;
      end else if (wr_en_i && wr_idx_i == IW'(g)) begin
        tag_o[g] <= wr_tag_i;
        tgt_o[g] <= wr_tgt_i;
      end
    end
  end
endmodule

// File: rtl/btb_alloc.sv
module btb_alloc #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [IW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == IW'(N - 1)) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
  import btb_pkg::*;
#(
  parameter int N    = 16,
  parameter int PC_W = 32,
  localparam int IW  = $clog2(N),
  localparam int TW  = PC_W - 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            res_taken_i,
  input  logic [PC_W-1:0] res_target_i,
  input  logic            res_hit_i,
  input  logic [PC_W-1:0] res_pred_npc_i,
  input  logic            found_i,
  input  logic [IW-1:0]   found_idx_i,
  input  logic [IW-1:0]   rr_ptr_i,
  output logic            wr_en_o,
  output logic [IW-1:0]   wr_idx_o,
  output logic [TW-1:0]   wr_tag_o,
  output logic [TW-1:0]   wr_tgt_o,
  output logic            inv_en_o,
  output logic            adv_o,
  output logic            kill_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic [1:0]      outcome_o
);
  outcome_e        cls;
  logic            bad;
  logic [PC_W-1:0] fix_pc;

  always_comb begin
    cls = OUT_OK;
    if (res_hit_i) begin
      if (!res_taken_i || res_target_i != res_pred_npc_i) cls = OUT_BAD_HIT;
    end else if (res_taken_i) begin
      cls = OUT_TAKEN_MISS;
    end
  end

  assign bad    = (cls != OUT_OK);
  assign fix_pc = res_taken_i ? res_target_i : res_pc_i + PC_W'(4);

  // table update: taken writes (existing slot or new), not-taken drops
  assign wr_en_o  = res_valid_i && res_taken_i;
  assign wr_idx_o = found_i ? found_idx_i : rr_ptr_i;
  assign wr_tag_o = res_pc_i[PC_W-1:2];
  assign wr_tgt_o = res_target_i[PC_W-1:2];
  assign adv_o    = wr_en_o && !found_i;
  assign inv_en_o = res_valid_i && !res_taken_i && found_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kill_o        <= 1'b0;
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
      outcome_o     <= OUT_OK;
    end else begin
      kill_o     <= res_valid_i && bad;
      redirect_o <= res_valid_i && bad;
      if (res_valid_i) begin
        redirect_pc_o <= fix_pc;
        outcome_o     <= cls;
      end
    end
  end
endmodule

// File: rtl/btb_top.sv
module btb_top
  import btb_pkg::*;
#(
  parameter int N    = 16,
  parameter int PC_W = 32,
  localparam int IW  = $clog2(N),
  localparam int TW  = PC_W - 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic            pred_hit_o,
  output logic [PC_W-1:0] pred_npc_o,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            res_taken_i,
  input  logic [PC_W-1:0] res_target_i,
  input  logic            res_hit_i,
  input  logic [PC_W-1:0] res_pred_npc_i,
  output logic            kill_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic [1:0]      outcome_o
);
  logic          ent_valid [N];
  logic [TW-1:0] ent_tag   [N];
  logic [TW-1:0] ent_tgt   [N];

  logic          f_hit, r_hit;
  logic [IW-1:0] f_idx, r_idx;
  logic [N-1:0]  f_match, r_match;

  logic          wr_en, inv_en, adv;
  logic [IW-1:0] wr_idx, rr_ptr;
  logic [TW-1:0] wr_tag, wr_tgt;

  btb_cam #(.N(N), .TW(TW)) u_fetch_cam (
    .valid_i(ent_valid), .tag_i(ent_tag), .key_i(fetch_pc_i[PC_W-1:2]),
    .hit_o(f_hit), .idx_o(f_idx), .match_o(f_match)
  );

  btb_cam #(.N(N), .TW(TW)) u_res_cam (
    .valid_i(ent_valid), .tag_i(ent_tag), .key_i(res_pc_i[PC_W-1:2]),
    .hit_o(r_hit), .idx_o(r_idx), .match_o(r_match)
  );

  btb_store #(.N(N), .TW(TW)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_tag_i(wr_tag), .wr_tgt_i(wr_tgt),
    .inv_en_i(inv_en), .inv_idx_i(r_idx),
    .valid_o(ent_valid), .tag_o(ent_tag), .tgt_o(ent_tgt)
  );

  btb_alloc #(.N(N)) u_alloc (
    .clk_i, .rst_ni, .adv_i(adv), .ptr_o(rr_ptr)
  );

  btb_resolve #(.N(N), .PC_W(PC_W)) u_resolve (
    .clk_i, .rst_ni,
    .res_valid_i, .res_pc_i, .res_taken_i, .res_target_i, .res_hit_i, .res_pred_npc_i,
    .found_i(r_hit), .found_idx_i(r_idx), .rr_ptr_i(rr_ptr),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_tag_o(wr_tag), .wr_tgt_o(wr_tgt),
    .inv_en_o(inv_en), .adv_o(adv),
    .kill_o, .redirect_o, .redirect_pc_o, .outcome_o
  );

  assign pred_hit_o = f_hit;
  assign pred_npc_o = f_hit ? {ent_tgt[f_idx], 2'b00} : fetch_pc_i + PC_W'(4);
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int N    = 16,
  parameter int PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] fetch_pc_i,
  input logic            pred_hit_o,
  input logic [PC_W-1:0] pred_npc_o,
  input logic            res_valid_i,
  input logic [PC_W-1:0] res_pc_i,
  input logic            res_taken_i,
  input logic [PC_W-1:0] res_target_i,
  input logic            res_hit_i,
  input logic [PC_W-1:0] res_pred_npc_i,
  input logic            kill_o,
  input logic            redirect_o,
  input logic [PC_W-1:0] redirect_pc_o,
  input logic [1:0]      outcome_o,
  input logic [N-1:0]    fetch_match
);
  a_r2_miss_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_hit_o |-> pred_npc_o == fetch_pc_i + PC_W'(4));

  a_r3_taken_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !res_hit_i && res_taken_i) |=>
      (kill_o && redirect_o && outcome_o == 2'b10 && redirect_pc_o == $past(res_target_i)));

  a_r4_correct_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_hit_i && res_taken_i && res_target_i == res_pred_npc_i) |=>
      (!kill_o && !redirect_o && outcome_o == 2'b00));

  a_r5_not_taken_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_hit_i && !res_taken_i) |=>
      (kill_o && outcome_o == 2'b01 && redirect_pc_o == $past(res_pc_i) + PC_W'(4)));

  a_r7_quiet_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !res_hit_i && !res_taken_i) |=> (!kill_o && outcome_o == 2'b00));

  a_r8_kill_follows_resolve: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill_o || redirect_o) |-> $past(res_valid_i));

  a_r10_unique_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fetch_match));
endmodule

bind btb_top btb_checker #(.N(N), .PC_W(PC_W)) u_chk (
  .clk_i, .rst_ni, .fetch_pc_i, .pred_hit_o, .pred_npc_o,
  .res_valid_i, .res_pc_i, .res_taken_i, .res_target_i, .res_hit_i, .res_pred_npc_i,
  .kill_o, .redirect_o, .redirect_pc_o, .outcome_o,
  .fetch_match(f_match)
);

// File: tb/sim_btb_top.sv
`timescale 1ns/1ps
module sim_btb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_hit;
  logic [31:0] pred_npc;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic        res_taken = 1'b0;
  logic [31:0] res_target = '0;
  logic        res_hit = 1'b0;
  logic [31:0] res_pred = '0;
  logic        kill, redirect;
  logic [31:0] redirect_pc;
  logic [1:0]  outcome;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    logic        kill;
    logic [31:0] pc;
    logic [1:0]  cls;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  btb_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .fetch_pc_i(fetch_pc),
    .pred_hit_o(pred_hit), .pred_npc_o(pred_npc),
    .res_valid_i(res_valid), .res_pc_i(res_pc), .res_taken_i(res_taken),
    .res_target_i(res_target), .res_hit_i(res_hit), .res_pred_npc_i(res_pred),
    .kill_o(kill), .redirect_o(redirect), .redirect_pc_o(redirect_pc), .outcome_o(outcome)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: expected result is worked out from the requirement classes
  task automatic resolve(input logic [31:0] pc, input logic tk, input logic [31:0] tgt,
                         input logic hit, input logic [31:0] pred, input string req);
    exp_t e;
    e.req = req;
    if (hit && (!tk || tgt != pred)) e.cls = 2'b01;
    else if (!hit && tk)             e.cls = 2'b10;
    else                             e.cls = 2'b00;
    e.kill = (e.cls != 2'b00);
    e.pc   = tk ? tgt : pc + 32'd4;
    @(negedge clk);
    res_valid = 1'b1; res_pc = pc; res_taken = tk; res_target = tgt;
    res_hit = hit; res_pred = pred;
    exp_q.push_back(e);
    @(negedge clk);
    res_valid = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pop and compare one cycle after each resolve; R8 pulse check
  logic prev_kill = 1'b0;
  always @(posedge clk) begin
    automatic logic fired = res_valid && rst_n;
    #1;
    if (fired && exp_q.size() > 0) begin
      automatic exp_t e = exp_q.pop_front();
      check(kill == e.kill && redirect == e.kill, {e.req, " kill/redirect"}, {30'd0, redirect, kill}, {30'd0, e.kill, e.kill});
      if (e.kill) check(redirect_pc == e.pc, {e.req, " redirect_pc"}, redirect_pc, e.pc);
      check(outcome == e.cls, {e.req, " outcome"}, {30'd0, outcome}, {30'd0, e.cls});
    end else if (prev_kill) begin
      check(!kill && !redirect, "R8 single pulse", {31'd0, kill}, 32'd0);
    end
    prev_kill = kill;
  end

  task automatic lookup(input logic [31:0] pc, input logic hit, input logic [31:0] npc, input string req);
    @(negedge clk);
    fetch_pc = pc;
    #1;
    check(pred_hit == hit, {req, " hit"}, {31'd0, pred_hit}, {31'd0, hit});
    check(pred_npc == npc, {req, " npc"}, pred_npc, npc);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", exp_q.size());
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 / R2
    #1;
    check(!kill && !redirect, "R1 reset outputs", {30'd0, redirect, kill}, 32'd0);
    lookup(32'h1000, 1'b0, 32'h1004, "R1 R2 miss after reset");

    // R3 taken miss inserts
    resolve(32'h1000, 1'b1, 32'h2000, 1'b0, 32'h1004, "R3");
    lookup(32'h1000, 1'b1, 32'h2000, "R3 inserted");

    // R4 correct
    resolve(32'h1000, 1'b1, 32'h2000, 1'b1, 32'h2000, "R4");
    lookup(32'h1000, 1'b1, 32'h2000, "R4 kept");

    // R6 wrong target
    resolve(32'h1000, 1'b1, 32'h3000, 1'b1, 32'h2000, "R6");
    lookup(32'h1000, 1'b1, 32'h3000, "R6 target updated");

    // R5 not taken invalidates
    resolve(32'h1000, 1'b0, 32'h0, 1'b1, 32'h3000, "R5");
    lookup(32'h1000, 1'b0, 32'h1004, "R5 invalidated");

    // R7 quiet miss
    resolve(32'h1100, 1'b0, 32'h0, 1'b0, 32'h1104, "R7");
    lookup(32'h1100, 1'b0, 32'h1104, "R7 not inserted");

    // R9 / R10 round robin and duplicate
    do_reset();
    lookup(32'h1000, 1'b0, 32'h1004, "R1 cleared by reset");
    for (int i = 0; i < 16; i++)
      resolve(32'h4000 + 32'(i * 16), 1'b1, 32'h8000 + 32'(i * 16), 1'b0, 32'h4004 + 32'(i * 16), "R9 fill");
    for (int i = 0; i < 16; i++)
      lookup(32'h4000 + 32'(i * 16), 1'b1, 32'h8000 + 32'(i * 16), "R9 all held");
    resolve(32'h4050, 1'b1, 32'h9000, 1'b0, 32'h4054, "R10 re-insert");
    resolve(32'h5000, 1'b1, 32'hA000, 1'b0, 32'h5004, "R9 evict");
    lookup(32'h4000, 1'b0, 32'h4004, "R9 oldest evicted");
    lookup(32'h4010, 1'b1, 32'h8010, "R10 pointer not advanced");
    lookup(32'h4050, 1'b1, 32'h9000, "R10 entry rewritten");
    lookup(32'h5000, 1'b1, 32'hA000, "R9 new entry");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R8 all results seen", exp_q.size(), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule